// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A synthesizable model of a synchronous static RAM with a registered read path and a two-bit burst sequencer. Every address, write data word, chip enable, burst control and write control is taken on the rising clock edge. A base address is loaded by one of two address strobes. A burst of up to four beats then runs, stepped by an advance input, in either linear or interleaved order, and wraps after the fourth beat.

Reads come back through an output register one clock after the access is registered. The output drive flag follows a double-cycle deselect: it stays on for one extra cycle after the chip is deselected. An asynchronous output enable gates the drive flag without waiting for a clock. The shared data bus is modelled with split in and out ports plus a drive flag, which is the separate data-in/data-out arrangement used for testing. Writes use active-low per-lane enables, and an active-low global write overrides them.

Top module: `sbs_pipe_sram`

## Requirements
- R1: After reset, dq_oe is 0 and dq_out is 0.
- R2: On a cycle with a strobe, the chip is selected only when ce_n=0, ce2=1 and ce2_n=0. Any other combination deselects it, and no write takes place on that cycle.
- R3: adsp_n=0 with the chip selected starts a read at addr, even with gw_n or bw_n asserted. Storage is left unchanged. adsp_n takes priority over adsc_n.
- R4: adsc_n=0 (adsp_n=1) with the chip selected writes when gw_n=0 or any bw_n bit is 0. gw_n=0 writes every lane. Otherwise, lane i (bits 8i+7:8i) is written only when bw_n[i]=0.
- R5: A read registered at edge k shows its word on dq_out, with dq_oe=1 (oe_n=0), after edge k+1 and not earlier.
- R6: With lin_mode=1, beat n of a burst uses the base address with its two low bits replaced by (base[1:0]+n) mod 4. The upper bits are unchanged.
- R7: With lin_mode=0, beat n uses the low bits base[1:0] XOR n.
- R8: A burst wraps: the fifth beat uses the same address as the first.
- R9: During a burst, a cycle with adsp_n=1, adsc_n=1 and adv_n=1 repeats the access at the current burst address. adv_n=0 steps to the next beat at that edge.
- R10: A burst continuation with gw_n=0 or bw_n asserted writes at the stepped burst address.
- R11: dq_oe equals the internal drive state gated by oe_n=0, and it follows oe_n without a clock edge.
- R12: If a deselect is registered at edge d after a read, dq_oe stays 1 after edge d+1 and falls after edge d+2 unless a new read was issued.
- R13: A write registered at edge k turns the drive off after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address, loaded on a strobe |
| ce_n | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| ce2_n | input | 1 | Active-low chip enable |
| adsp_n | input | 1 | Active-low read-start strobe (priority) |
| adsc_n | input | 1 | Active-low strobe, read or write |
| adv_n | input | 1 | Active-low burst advance |
| gw_n | input | 1 | Active-low global write, all lanes |
| bw_n | input | LANES | Active-low per-lane write enables |
| lin_mode | input | 1 | 1 linear burst order, 0 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | LANES*LANE_W | Write data, taken with the access |
| dq_out | output | LANES*LANE_W | Read data from the output register |
| dq_oe | output | 1 | Bus drive flag; 0 means high impedance |

## Verification
Inputs change on the falling edge and outputs are sampled on the falling edge just before the next change. A read issued before edge k is therefore checked after edge k+1, one sample later than it was driven. Burst reads are checked with a one-beat lag: each sample holds the beat issued one step earlier. The drive flag is sampled after edge d+1 and after edge d+2 following a deselect, and one and two edges after a write. Writes are confirmed by later reads at the same address. The output enable is toggled between clock edges and checked a nanosecond later.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } sbs_op_e;
endpackage

// File: rtl/sbs_chip_sel.sv
module sbs_chip_sel (
  input  logic ce_n,
  input  logic ce2,
  input  logic ce2_n,
  output logic sel
);
  assign sel = ~ce_n & ce2 & ~ce2_n;
endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
  import sbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          sel,
  input  logic          wr_req,
  input  logic          lin_mode,
  input  logic [AW-1:0] addr_in,
  output sbs_op_e       op,
  output logic [AW-1:0] acc_addr
);
  logic          active_q;
  logic [AW-1:0] base_q;
  logic [1:0]    beat_q, beat_nxt, use_beat, lo;
  logic          strobe;

  assign strobe   = ~adsp_n | ~adsc_n;
  assign beat_nxt = beat_q + 2'd1;
  assign use_beat = adv_n ? beat_q : beat_nxt;
  assign lo       = lin_mode ? (base_q[1:0] + use_beat) : (base_q[1:0] ^ use_beat);

  always_comb begin
    op       = OP_IDLE;
    acc_addr = addr_in;
    if (!adsp_n) begin
      op = sel ? OP_READ : OP_DESEL;
    end else if (!adsc_n) begin
      op = sel ? (wr_req ? OP_WRITE : OP_READ) : OP_DESEL;
    end else if (active_q) begin
      acc_addr = {base_q[AW-1:2], lo};
      op       = wr_req ? OP_WRITE : OP_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      beat_q   <= 2'd0;
    end else if (strobe) begin
      active_q <= sel;
      base_q   <= addr_in;
      beat_q   <= 2'd0;
    end else if (active_q && !adv_n) begin
      beat_q <= beat_nxt;
    end
  end

  AST_ADSP_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && sel) |-> (op == OP_READ)); // R3
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !strobe && adv_n) |=> $stable(beat_q)); // R9
  AST_STEP_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !strobe && !adv_n) |=> (beat_q == $past(beat_q) + 2'd1)); // R8
  AST_NO_SEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !sel) |-> (op == OP_DESEL)); // R2
endmodule

// File: rtl/sbs_store.sv
module sbs_store #(
  parameter int AW    = 6,
  parameter int NB    = 2,
  parameter int LW    = 8,
  localparam int DW   = NB * LW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [NB-1:0] lanes,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata_q
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] bitmask;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign bitmask[g*LW +: LW] = {LW{lanes[g]}};
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= (mem[addr] & ~bitmask) | (wdata & bitmask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= mem[addr];
  end
endmodule

// File: rtl/sbs_pipe_sram.sv
module sbs_pipe_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              ce2,
  input  logic              ce2_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              lin_mode,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  logic              sel, wr_req;
  logic [LANES-1:0]  lanes_c, s1_lanes;
  sbs_op_e           op_c, s1_op;
  logic [ADDR_W-1:0] acc_addr, s1_addr;
  logic [DATA_W-1:0] s1_data;
  logic              drv, s2_desel;

  assign lanes_c = gw_n ? ~bw_n : {LANES{1'b1}};
  assign wr_req  = |lanes_c;

  sbs_chip_sel u_sel (.ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .sel(sel));

  sbs_burst_seq #(.AW(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .sel(sel), .wr_req(wr_req), .lin_mode(lin_mode), .addr_in(addr),
    .op(op_c), .acc_addr(acc_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_op    <= OP_IDLE;
      s1_addr  <= '0;
      s1_data  <= '0;
      s1_lanes <= '0;
    end else begin
      s1_op    <= op_c;
      s1_addr  <= acc_addr;
      s1_data  <= dq_in;
      s1_lanes <= (op_c == OP_WRITE) ? lanes_c : '0;
    end
  end

  sbs_store #(.AW(ADDR_W), .NB(LANES), .LW(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(s1_op == OP_WRITE), .re(s1_op == OP_READ),
    .lanes(s1_lanes), .addr(s1_addr), .wdata(s1_data), .rdata_q(dq_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv      <= 1'b0;
      s2_desel <= 1'b0;
    end else begin
      s2_desel <= (s1_op == OP_DESEL);
      if (s1_op == OP_READ)       drv <= 1'b1;
      else if (s1_op == OP_WRITE) drv <= 1'b0;
      else if (s2_desel)          drv <= 1'b0;
    end
  end

  assign dq_oe = drv & ~oe_n;

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_op == OP_READ) |=> drv); // R5
  AST_WRITE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_op == OP_WRITE) |-> (s1_lanes != '0)); // R4
  AST_DESEL_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_op == OP_DESEL && !s2_desel && drv) |=> drv); // R12
  AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_op == OP_DESEL) ##1 (s1_op != OP_READ) |=> !drv); // R12
  AST_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_op == OP_WRITE) |=> !drv); // R13
endmodule

// File: tb/sim_sbs_pipe_sram.sv
module sim_sbs_pipe_sram;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ce_n, ce2, ce2_n, adsp_n, adsc_n, adv_n, gw_n, lin_mode, oe_n;
  logic [NB-1:0] bw_n;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe;
  logic [DW-1:0] model [64];
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sbs_pipe_sram u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bw_n(bw_n),
    .lin_mode(lin_mode), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bw_n = '1;
    ce_n = 0; ce2 = 1; ce2_n = 0;
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input logic lin, input int n);
    logic [1:0] nn = 2'(n);
    return lin ? {b[AW-1:2], 2'(b[1:0] + nn)} : {b[AW-1:2], b[1:0] ^ nn};
  endfunction

  task automatic deselect();
    idle(); adsp_n = 0; ce_n = 1; step();
    idle(); step(); step();
  endtask

  task automatic read_one(input logic [AW-1:0] a, input string req);
    idle(); adsp_n = 0; addr = a; step();
    idle(); step();
    chk(req, {15'd0, dq_oe}, 16'd1);
    chk(req, dq_out, model[a]);
    deselect();
  endtask

  task automatic t_reset();
    chk("R1", {15'd0, dq_oe}, 16'd0);
    chk("R1", dq_out, 16'd0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < 64; a++) begin
      idle(); adsc_n = 0; gw_n = 0; addr = AW'(a);
      dq_in = 16'hA500 ^ (16'(a) * 16'h0123);
      model[a] = dq_in;
      step();
    end
    deselect();
    read_one(6'd17, "R4");
  endtask

  task automatic t_latency();
    idle(); adsp_n = 0; addr = 6'd7; step();
    chk("R5", {15'd0, dq_oe}, 16'd0);
    idle(); step();
    chk("R5", {15'd0, dq_oe}, 16'd1);
    chk("R5", dq_out, model[7]);
    deselect();
  endtask

  task automatic t_adsp_read();
    idle(); adsp_n = 0; adsc_n = 0; gw_n = 0; bw_n = '0; addr = 6'd9; dq_in = 16'hFFFF; step();
    idle(); step();
    chk("R3", dq_out, model[9]);
    deselect();
    read_one(6'd9, "R3");
  endtask

  task automatic t_bytes();
    idle(); adsc_n = 0; bw_n = 2'b10; addr = 6'd12; dq_in = 16'h1234; step();
    model[12] = {model[12][15:8], 8'h34};
    deselect();
    idle(); adsc_n = 0; gw_n = 0; bw_n = 2'b11; addr = 6'd13; dq_in = 16'hBEEF; step();
    model[13] = 16'hBEEF;
    deselect();
    read_one(6'd12, "R4");
    read_one(6'd13, "R4");
  endtask

  task automatic burst_read(input logic [AW-1:0] b, input logic lin, input int n, input string req);
    lin_mode = lin;
    idle(); adsp_n = 0; addr = b; step();
    for (int i = 1; i < n; i++) begin
      idle(); adv_n = 0; step();
      chk(req, dq_out, model[beat_addr(b, lin, i - 1)]);
    end
    idle(); step();
    chk(req, dq_out, model[beat_addr(b, lin, n - 1)]);
    deselect();
  endtask

  task automatic t_wrap();
    lin_mode = 1;
    idle(); adsp_n = 0; addr = 6'd22; step();
    for (int i = 1; i < 5; i++) begin idle(); adv_n = 0; step(); end
    idle(); step();
    chk("R8", dq_out, model[22]);
    deselect();
  endtask

  task automatic t_hold();
    lin_mode = 1;
    idle(); adsp_n = 0; addr = 6'd20; step();
    idle(); step(); chk("R9", dq_out, model[20]);
    idle(); step(); chk("R9", dq_out, model[20]);
    idle(); adv_n = 0; step(); chk("R9", dq_out, model[20]);
    idle(); step(); chk("R9", dq_out, model[21]);
    deselect();
  endtask

  task automatic t_burst_write();
    lin_mode = 1;
    idle(); adsc_n = 0; gw_n = 0; addr = 6'd32; dq_in = 16'h0A0A; step();
    idle(); adv_n = 0; gw_n = 0; dq_in = 16'h0B0B; step();
    model[32] = 16'h0A0A; model[33] = 16'h0B0B;
    deselect();
    read_one(6'd32, "R10");
    read_one(6'd33, "R10");
  endtask

  task automatic t_chip_sel();
    for (int c = 0; c < 8; c++) begin
      if (c == 2) continue;
      idle(); adsc_n = 0; gw_n = 0; addr = 6'd40; dq_in = 16'hDEAD;
      {ce_n, ce2, ce2_n} = 3'(c);
      step();
    end
    deselect();
    read_one(6'd40, "R2");
  endtask

  task automatic t_oe();
    idle(); adsp_n = 0; addr = 6'd3; step();
    idle(); step();
    #1 oe_n = 1; #1;
    chk("R11", {15'd0, dq_oe}, 16'd0);
    oe_n = 0; #1;
    chk("R11", {15'd0, dq_oe}, 16'd1);
    deselect();
  endtask

  task automatic t_desel_extra();
    idle(); adsp_n = 0; addr = 6'd3; step();
    idle(); step();
    idle(); adsp_n = 0; ce_n = 1; step();
    chk("R12", {15'd0, dq_oe}, 16'd1);
    idle(); step();
    chk("R12", {15'd0, dq_oe}, 16'd1);
    step();
    chk("R12", {15'd0, dq_oe}, 16'd0);
  endtask

  task automatic t_write_off();
    idle(); adsp_n = 0; addr = 6'd3; step();
    idle(); step();
    idle(); adsc_n = 0; gw_n = 0; addr = 6'd50; dq_in = 16'h5050; step();
    model[50] = 16'h5050;
    chk("R13", {15'd0, dq_oe}, 16'd1);
    idle(); step();
    chk("R13", {15'd0, dq_oe}, 16'd0);
    deselect();
    read_one(6'd50, "R13");
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); addr = '0; dq_in = '0; lin_mode = 1; oe_n = 0;
    step(); step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_fill();
    t_latency();
    t_adsp_read();
    t_bytes();
    burst_read(6'd6, 1'b1, 4, "R6");
    burst_read(6'd13, 1'b0, 4, "R7");
    burst_read(6'd42, 1'b0, 4, "R7");
    t_wrap();
    t_hold();
    t_burst_write();
    t_chip_sel();
    t_oe();
    t_desel_extra();
    t_write_off();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule